// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two 8-bit two's-complement integers over several clock cycles using radix-2 Booth recoding. A one-cycle load pulse captures both operands in parallel, clears the partial-product accumulator and clears the extra recoding bit that sits below the multiplier LSB. A later start pulse launches the run. Each run cycle looks at the multiplier LSB and the extra bit. Depending on that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator as it is. It then shifts the chained accumulator, multiplier and extra bit right by one place, copying the sign bit.

After the fixed number of iterations the chained accumulator and multiplier hold the signed 16-bit product and a done flag rises. The product stays on the output until the next load. All control inputs are sampled on the rising clock edge. The adder is one bit wider than the accumulator, so a multiplicand of -128 is handled correctly.

Top module: `booth_mul`

## Requirements
- R1: After reset is released, done_o is 0 and prod_o is 0.
- R2: A load_i pulse sampled while no run is in progress captures mcand_i and mplier_i in that one edge. It clears the accumulator and the recoding bit and drops done_o. From the next cycle prod_o reads {8'h00, mplier_i}.
- R3: A start_i pulse sampled while idle, with load_i low, begins a run. done_o is 0 through the first eight edges counted from and including the sampling edge, and it rises on the ninth.
- R4: On each iteration the pair (multiplier LSB, recoding bit) selects the action. A pair of 01 adds the multiplicand, 10 subtracts it, and 00 or 11 leaves the accumulator unchanged. An arithmetic right shift follows. When done_o rises, prod_o equals the signed product mcand_i × mplier_i.
- R5: Operand value -128 gives exact results in either position, including -128 × -128 = 16384 and -128 × 127 = -16256.
- R6: load_i and start_i are ignored while a run is in progress. The finished product is that of the operands loaded before the run.
- R7: start_i sampled while done_o is high is ignored. done_o stays high and prod_o is unchanged.
- R8: When load_i and start_i are high on the same edge, the load takes effect and no run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Synchronous parallel load of both operands |
| start_i | input | 1 | Synchronous run request |
| mcand_i | input | 8 | Multiplicand, two's complement |
| mplier_i | input | 8 | Multiplier, two's complement |
| prod_o | output | 16 | Chained accumulator and multiplier; the signed product once done |
| done_o | output | 1 | High from run completion until the next load |

## Verification
A load is visible on prod_o one edge after it is sampled. The done flag and the product are due on the ninth rising edge, counting the edge that samples start. The bench drives every input on the falling edge. It reads done_o as low after the eighth edge and as high, together with the product, after the ninth, sampling each value at the falling edge that follows. The ignored-stimulus cases are checked at the same due edges, or after more than a full run length has gone by with the outputs held.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;
  typedef enum logic [1:0] {OP_NOP, OP_ADD, OP_SUB} op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic q0_i,
  input  logic qm1_i,
  output op_e  op_o
);
  always_comb begin
    unique case ({q0_i, qm1_i})
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_NOP;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int unsigned ITERS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic start_i,
  output logic load_en_o,
  output logic step_en_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign load_en_o = load_i && (state_q != ST_RUN);
  assign step_en_o = (state_q == ST_RUN);
  assign done_o    = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          state_d = ST_IDLE;
        end else if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LAST) state_d = ST_DONE;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_DONE: begin
        if (load_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_done_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_RUN && cnt_q == LAST));

  assert_start_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !load_i) |=> (state_q == ST_RUN && cnt_q == '0));

  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN && load_i) |=> (state_q == ST_IDLE));

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic               step_en_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int unsigned EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] mcand_q, acc_q, mq_q;
  logic             qm1_q;
  logic [EXT_W-1:0] acc_ext, mcand_ext, sum;
  op_e              op;

  booth_recode u_recode (
    .q0_i  (mq_q[0]),
    .qm1_i (qm1_q),
    .op_o  (op)
  );

  // One guard bit keeps 0 - (-2^(W-1)) representable before the shift.
  assign acc_ext   = {acc_q[WIDTH-1], acc_q};
  assign mcand_ext = {mcand_q[WIDTH-1], mcand_q};

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc_ext + mcand_ext;
      OP_SUB:  sum = acc_ext - mcand_ext;
      default: sum = acc_ext;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mq_q    <= '0;
      qm1_q   <= 1'b0;
    end else if (load_en_i) begin
      mcand_q <= mcand_i;
      acc_q   <= '0;
      mq_q    <= mplier_i;
      qm1_q   <= 1'b0;
    end else if (step_en_i) begin
      acc_q   <= sum[EXT_W-1:1];
      mq_q    <= {sum[0], mq_q[WIDTH-1:1]};
      qm1_q   <= mq_q[0];
    end
  end

  assign prod_o = {acc_q, mq_q};

  assert_load_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> (acc_q == '0 && !qm1_q && mq_q == $past(mplier_i) && mcand_q == $past(mcand_i)));

  assert_mcand_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i |=> $stable(mcand_q));

  assert_recode_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && (mq_q[0] == qm1_q)) |=> (acc_q == $past(acc_q[WIDTH-1:1]) || acc_q[WIDTH-1] == $past(acc_q[WIDTH-1])));
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o,
  output logic               done_o
);
  logic load_en, step_en;

  booth_ctrl #(.ITERS(WIDTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .start_i   (start_i),
    .load_en_o (load_en),
    .step_en_o (step_en),
    .done_o    (done_o)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_en_i (load_en),
    .step_en_i (step_en),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .prod_o    (prod_o)
  );

  assert_result_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> $stable(prod_o));

  assert_run_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_en, done_o}));
endmodule

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  mcand_i = '0;
  logic [7:0]  mplier_i = '0;
  logic [15:0] prod_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  booth_mul dut (.*);

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] smul(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = $signed(a) * $signed(b);
    return p[15:0];
  endfunction

  task automatic do_load(input logic [7:0] a, input logic [7:0] b, input bit with_start);
    @(negedge clk_i);
    load_i = 1'b1; start_i = with_start; mcand_i = a; mplier_i = b;
    @(negedge clk_i);
    load_i = 1'b0; start_i = 1'b0;
  endtask

  // Start then wait to the ninth edge; optional ignored pulses mid-run.
  task automatic run(input logic [7:0] a, input logic [7:0] b, input string req, input bit timing, input bit disturb);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      if (disturb && i == 2) begin
        load_i = 1'b1; start_i = 1'b1; mcand_i = ~a; mplier_i = b ^ 8'h5a;
      end else begin
        load_i = 1'b0; start_i = 1'b0;
      end
    end
    if (timing) check(done_o == 1'b0, "R3 done early", {15'b0, done_o}, 16'h0);
    @(negedge clk_i);
    if (timing) check(done_o == 1'b1, "R3 done late", {15'b0, done_o}, 16'h1);
    check(prod_o == smul(a, b) && done_o, req, prod_o, smul(a, b));
  endtask

  task automatic t_reset();
    check(done_o == 1'b0 && prod_o == 16'h0, "R1 reset", prod_o, 16'h0);
  endtask

  task automatic t_load();
    do_load(8'h13, 8'hc5, 0);
    check(prod_o == 16'h00c5 && !done_o, "R2 load view", prod_o, 16'h00c5);
  endtask

  task automatic t_directed();
    logic [7:0] av [8] = '{8'h03, 8'hfd, 8'h07, 8'h00, 8'h55, 8'haa, 8'hff, 8'h01};
    logic [7:0] bv [8] = '{8'h05, 8'h06, 8'hf9, 8'h7f, 8'haa, 8'h55, 8'hff, 8'h80};
    for (int i = 0; i < 8; i++) begin
      do_load(av[i], bv[i], 0);
      run(av[i], bv[i], "R4 product", i < 2, 0);
    end
  endtask

  task automatic t_min();
    do_load(8'h80, 8'h80, 0); run(8'h80, 8'h80, "R5 -128*-128", 0, 0);
    check(prod_o == 16'h4000, "R5 +16384", prod_o, 16'h4000);
    do_load(8'h80, 8'h7f, 0); run(8'h80, 8'h7f, "R5 -128*127", 0, 0);
    do_load(8'h7f, 8'h80, 0); run(8'h7f, 8'h80, "R5 127*-128", 0, 0);
    do_load(8'h80, 8'h01, 0); run(8'h80, 8'h01, "R5 -128*1", 0, 0);
  endtask

  task automatic t_busy();
    do_load(8'h2d, 8'he3, 0);
    run(8'h2d, 8'he3, "R6 busy ignore", 1, 1);
  endtask

  task automatic t_done_start();
    logic [15:0] keep;
    do_load(8'hb7, 8'h39, 0);
    run(8'hb7, 8'h39, "R4 product", 0, 0);
    keep = prod_o;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check(done_o && prod_o == keep, "R7 start in done", prod_o, keep);
  endtask

  task automatic t_load_start();
    do_load(8'h61, 8'h9e, 1);
    repeat (10) @(negedge clk_i);
    check(!done_o && prod_o == 16'h009e, "R8 load wins", prod_o, 16'h009e);
    run(8'h61, 8'h9e, "R8 later run", 1, 0);
  endtask

  task automatic t_sweep();
    for (int a = -128; a < 128; a++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] ba, bb;
        ba = 8'(a);
        bb = 8'(k * 17 - 128);
        do_load(ba, bb, 0);
        run(ba, bb, "R4 sweep", 0, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_directed();
    t_min();
    t_busy();
    t_done_start();
    t_load_start();
    t_sweep();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule